// File: doc/BRIEF.md
# Half-Band Rate Conversion Sequencer

This block is the rate-matching shell that sits around a fixed-coefficient half-band low-pass filter. A single master clock runs at the faster of the two sample rates. When interpolating, the block takes a new input word on every other clock and feeds a zero sample into the filter on each clock in between. When decimating, it loads the result register on every other clock and holds it otherwise. In the equal-rate and pass-through modes, every clock carries a sample and a result.

A one-bit alignment strobe decides which clocks are "take" edges. The edge where the strobe is first seen low after being high is always a take edge. After that the pattern alternates whether the strobe stays low or toggles at half the clock rate. Two-channel modes carry two interleaved streams. Once the first sample has been taken in these modes, the block stops responding to the strobe. The filter datapath itself is replaced by a zeroed delay line of fixed length, so that the phase and latency behaviour can be seen at the ports.

Top module: `hbrate_seq`

## Requirements
- R1: A synchronous active-high reset clears `core_smp_o` and `dout_o` to zero. The first clock edge after reset is a take edge.
- R2: In the interpolating modes (codes 2, 3, 5, 7), the scaled input word reaches `core_smp_o` only on take edges. On every other edge `core_smp_o` is loaded with zero.
- R3: An edge at which `sync_i` is sampled low, after it was sampled high on the previous edge, is a take edge whatever the free-running phase. The edge after it inserts a zero.
- R4: After alignment, take edges keep alternating with the same phase when `sync_i` is held low. They also keep that phase when `sync_i` is driven high on the non-take edges and low on the take edges.
- R5: In the decimating modes (codes 4, 6, 8), `dout_o` is loaded only on edges that are not take edges, and it holds its value on take edges.
- R6: In equal-rate (code 0) and pass-through (code 1), every edge loads both `core_smp_o` and `dout_o`, and `sync_i` has no effect on either.
- R7: The sample in the input register after edge k reaches `dout_o` at edge k+34, if that edge loads `dout_o`. In the double-latency modes (codes 5 and 6), it arrives at edge k+68.
- R8: `core_smp_o` is the sign-extended 12-bit input shifted left by 4 in the unity-gain interpolating modes (codes 2, 5, 7). It is shifted left by 3 in all other modes, which gives half gain in code 3.
- R9: In the two-channel modes (codes 7 and 8), a take edge with `sync_i` low locks the phase. A later high-to-low change of `sync_i` then does not force a take edge. The lock is released by reset or by leaving these modes.
- R10: Mode codes: 0 equal-rate, 1 pass-through, 2 interpolate unity gain, 3 interpolate half gain, 4 decimate, 5 double-latency interpolate, 6 double-latency decimate, 7 two-channel interpolate, 8 two-channel decimate. Codes 9 to 15 behave as code 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, all registers on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 4 | Operating mode code (R10) |
| sync_i | input | 1 | Phase alignment strobe |
| din_i | input | 12 | Two's complement input sample |
| core_smp_o | output | 16 | Scaled or zero sample handed to the filter core |
| dout_o | output | 16 | Output result register |

## Verification
The alternation checks assume that the take pattern can only break at a high-to-low change of `sync_i`, so they exclude exactly those edges. They also assume that the mode seen at an edge is the mode that edge acts on. The stimulus changes `mode_i` only while reset is held, so no check ever spans a mode switch. The bench drives the strobe in three ways: misaligned single pulses, a steady low level, and a half-rate square wave. In the equal-rate and two-channel runs it drives random strobe values, so that the cases where the strobe must be ignored are covered.

// File: rtl/hbrs_pkg.sv
`timescale 1ns/1ps
package hbrs_pkg;

    localparam int DEF_IN_W     = 12;
    localparam int DEF_CORE_W   = 16;
    localparam int DEF_BASE_LAT = 34;

    typedef enum logic [3:0] {
        RM_EQUAL    = 4'd0,
        RM_PASS     = 4'd1,
        RM_INT_UNIT = 4'd2,
        RM_INT_HALF = 4'd3,
        RM_DEC      = 4'd4,
        RM_INT_DBL  = 4'd5,
        RM_DEC_DBL  = 4'd6,
        RM_INT_PAIR = 4'd7,
        RM_DEC_PAIR = 4'd8
    } rate_mode_e;

    typedef struct packed {
        logic stuff;   // zero insertion on non-take edges
        logic strobe;  // output loads only on non-take edges
        logic unity;   // extra doubling of accepted samples
        logic dbl;     // double pipeline latency
        logic pair;    // two-channel phase lock
    } mode_ctl_t;

    function automatic logic mode_stuffs(input logic [3:0] code);
        return (code == RM_INT_UNIT) || (code == RM_INT_HALF) ||
               (code == RM_INT_DBL)  || (code == RM_INT_PAIR);
    endfunction

    function automatic logic mode_strobes(input logic [3:0] code);
        return (code == RM_DEC) || (code == RM_DEC_DBL) || (code == RM_DEC_PAIR);
    endfunction

    function automatic logic mode_unity(input logic [3:0] code);
        return (code == RM_INT_UNIT) || (code == RM_INT_DBL) || (code == RM_INT_PAIR);
    endfunction

    function automatic logic mode_double(input logic [3:0] code);
        return (code == RM_INT_DBL) || (code == RM_DEC_DBL);
    endfunction

    function automatic logic mode_paired(input logic [3:0] code);
        return (code == RM_INT_PAIR) || (code == RM_DEC_PAIR);
    endfunction

    function automatic mode_ctl_t decode_mode(input logic [3:0] code);
        mode_ctl_t c;
        c.stuff  = mode_stuffs(code);
        c.strobe = mode_strobes(code);
        c.unity  = mode_unity(code);
        c.dbl    = mode_double(code);
        c.pair   = mode_paired(code);
        return c;
    endfunction

endpackage

// File: rtl/hbrs_phase.sv
`timescale 1ns/1ps
module hbrs_phase (
    input  logic clk,
    input  logic rst,
    input  logic sync,
    input  logic pair,
    output logic take
);
    logic take_next;   // coming edge is a take edge when free-running
    logic sync_q;
    logic locked;
    logic forced;

    assign forced = sync_q & ~sync & ~locked;
    assign take   = forced | take_next;

    always_ff @(posedge clk) begin
        if (rst) begin
            take_next <= 1'b1;
            sync_q    <= 1'b0;
            locked    <= 1'b0;
        end else begin
            take_next <= ~take;
            sync_q    <= sync;
            locked    <= pair & (locked | (take & ~sync));
        end
    end
endmodule

// File: rtl/hbrs_feed.sv
`timescale 1ns/1ps
module hbrs_feed #(
    parameter int IN_W   = 12,
    parameter int CORE_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IN_W-1:0]   din,
    input  logic              take,
    input  logic              stuff,
    input  logic              unity,
    output logic [CORE_W-1:0] smp
);
    localparam int EXT   = CORE_W - IN_W;
    localparam int SHIFT = EXT - 1;

    logic [CORE_W-1:0] wide;
    logic [CORE_W-1:0] nxt;

    assign wide = {{EXT{din[IN_W-1]}}, din};

    always_comb begin
        if (stuff && !take)
            nxt = '0;
        else if (unity)
            nxt = wide << (SHIFT + 1);
        else
            nxt = wide << SHIFT;
    end

    always_ff @(posedge clk) begin
        if (rst) smp <= '0;
        else     smp <= nxt;
    end
endmodule

// File: rtl/hbrs_core_stub.sv
`timescale 1ns/1ps
module hbrs_core_stub #(
    parameter int CORE_W   = 16,
    parameter int BASE_LAT = 34
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CORE_W-1:0] smp,
    input  logic              dbl,
    output logic [CORE_W-1:0] tap
);
    localparam int DEPTH    = 2 * BASE_LAT - 1;
    localparam int TAP_ONE  = BASE_LAT - 2;
    localparam int TAP_TWO  = 2 * BASE_LAT - 2;

    logic [CORE_W-1:0] line [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) line[0] <= '0;
        else     line[0] <= smp;
    end

    for (genvar g = 1; g < DEPTH; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) line[g] <= '0;
            else     line[g] <= line[g-1];
        end
    end

    assign tap = dbl ? line[TAP_TWO] : line[TAP_ONE];
endmodule

// File: rtl/hbrs_outreg.sv
`timescale 1ns/1ps
module hbrs_outreg #(
    parameter int CORE_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CORE_W-1:0] tap,
    input  logic              strobe,
    input  logic              take,
    output logic [CORE_W-1:0] dout
);
    always_ff @(posedge clk) begin
        if (rst)
            dout <= '0;
        else if (!strobe || !take)
            dout <= tap;
    end
endmodule

// File: rtl/hbrate_seq.sv
`timescale 1ns/1ps
module hbrate_seq
    import hbrs_pkg::*;
#(
    parameter int IN_W     = DEF_IN_W,
    parameter int CORE_W   = DEF_CORE_W,
    parameter int BASE_LAT = DEF_BASE_LAT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        mode_i,
    input  logic              sync_i,
    input  logic [IN_W-1:0]   din_i,
    output logic [CORE_W-1:0] core_smp_o,
    output logic [CORE_W-1:0] dout_o
);
    mode_ctl_t         ctl;
    logic              take;
    logic [CORE_W-1:0] tap;

    assign ctl = decode_mode(mode_i);

    hbrs_phase phase_i (
        .clk  (clk),
        .rst  (rst),
        .sync (sync_i),
        .pair (ctl.pair),
        .take (take)
    );

    hbrs_feed #(.IN_W(IN_W), .CORE_W(CORE_W)) feed_i (
        .clk   (clk),
        .rst   (rst),
        .din   (din_i),
        .take  (take),
        .stuff (ctl.stuff),
        .unity (ctl.unity),
        .smp   (core_smp_o)
    );

    hbrs_core_stub #(.CORE_W(CORE_W), .BASE_LAT(BASE_LAT)) core_i (
        .clk (clk),
        .rst (rst),
        .smp (core_smp_o),
        .dbl (ctl.dbl),
        .tap (tap)
    );

    hbrs_outreg #(.CORE_W(CORE_W)) out_i (
        .clk    (clk),
        .rst    (rst),
        .tap    (tap),
        .strobe (ctl.strobe),
        .take   (take),
        .dout   (dout_o)
    );
endmodule

// File: rtl/hbrs_chk.sv
`timescale 1ns/1ps
module hbrs_chk
    import hbrs_pkg::*;
#(
    parameter int IN_W   = 12,
    parameter int CORE_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [3:0]        mode,
    input logic              sync,
    input logic [CORE_W-1:0] core_smp,
    input logic [CORE_W-1:0] dout
);
    localparam int SH = CORE_W - IN_W - 1;

    logic st, sb, un;
    assign st = mode_stuffs(mode);
    assign sb = mode_strobes(mode);
    assign un = mode_unity(mode);

    // R1
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (dout == '0 && core_smp == '0));

    // R2: two accepted samples never follow back to back unless SYNC falls
    a_r2_zero_between: assert property (@(posedge clk) disable iff (rst)
        (st && core_smp != '0 && !$fell(sync)) |=> core_smp == '0);

    // R5: an output load is always followed by a hold edge
    a_r5_hold_after_load: assert property (@(posedge clk) disable iff (rst)
        (sb && !$stable(dout)) |=> $stable(dout));

    // R8: unity-gain interpolation leaves SH+1 zero low bits
    a_r8_unity_scale: assert property (@(posedge clk) disable iff (rst)
        un |=> core_smp[SH:0] == '0);

    // R8: other modes keep one headroom bit and SH zero low bits
    a_r8_half_scale: assert property (@(posedge clk) disable iff (rst)
        !un |=> (core_smp[SH-1:0] == '0 && core_smp[CORE_W-1] == core_smp[CORE_W-2]));
endmodule

bind hbrate_seq hbrs_chk #(.IN_W(IN_W), .CORE_W(CORE_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode_i),
    .sync     (sync_i),
    .core_smp (core_smp_o),
    .dout     (dout_o)
);

// File: tb/hbrate_seq_tb_top.sv
`timescale 1ns/1ps
module hbrate_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  mode = 4'd0;
    logic        sync = 1'b0;
    logic [11:0] din = '0;
    logic [15:0] core_smp;
    logic [15:0] dout;

    int checks = 0;
    int failures = 0;
    string cur_tag = "R1";

    // behavioural reference state
    int  hist[$];
    bit  m_take_next, m_sync_prev, m_locked, m_take;
    int  exp_core, exp_dout;

    always #5 clk = ~clk;

    hbrate_seq dut_i (
        .clk(clk), .rst(rst), .mode_i(mode), .sync_i(sync), .din_i(din),
        .core_smp_o(core_smp), .dout_o(dout)
    );

    function automatic bit is_interp(input logic [3:0] m);
        return m == 2 || m == 3 || m == 5 || m == 7;
    endfunction
    function automatic bit is_decim(input logic [3:0] m);
        return m == 4 || m == 6 || m == 8;
    endfunction
    function automatic bit is_unity(input logic [3:0] m);
        return m == 2 || m == 5 || m == 7;
    endfunction
    function automatic bit is_dbl(input logic [3:0] m);
        return m == 5 || m == 6;
    endfunction
    function automatic bit is_pair(input logic [3:0] m);
        return m == 7 || m == 8;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    task automatic model_edge();
        int lat, sv, tapv;
        bit fall;
        if (rst) begin
            m_take_next = 1; m_sync_prev = 0; m_locked = 0; m_take = 0;
            hist.delete();
            exp_core = 0; exp_dout = 0;
            return;
        end
        fall = m_sync_prev && !sync && !m_locked;
        m_take = fall || m_take_next;
        m_take_next = !m_take;
        m_sync_prev = sync;
        m_locked = is_pair(mode) && (m_locked || (m_take && !sync));
        sv = int'($signed(din));
        if (is_interp(mode) && !m_take) exp_core = 0;
        else exp_core = (sv * (is_unity(mode) ? 16 : 8)) & 16'hFFFF;
        hist.push_back(exp_core);
        lat = is_dbl(mode) ? 68 : 34;
        tapv = (hist.size() > lat) ? hist[hist.size() - 1 - lat] : 0;
        if (!is_decim(mode) || !m_take) exp_dout = tapv;
    endtask

    task automatic step(input logic [11:0] d, input bit s);
        din = d; sync = s;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(int'(core_smp) == exp_core, cur_tag, "core_smp", int'(core_smp), exp_core);
        check(int'(dout) == exp_dout, cur_tag, "dout", int'(dout), exp_dout);
    endtask

    task automatic do_reset(input logic [3:0] m);
        mode = m;
        rst = 1'b1;
        repeat (3) step(12'h000, 1'b0);
        rst = 1'b0;
    endtask

    task automatic impulse_test(input logic [3:0] m, input int pre, input int lat,
                                input int val, input string tag);
        int first = -1;
        int seen = 0;
        cur_tag = tag;
        do_reset(m);
        for (int i = 0; i < pre; i++) step(12'h000, 1'b0);
        step(12'h040, 1'b0);
        for (int i = 1; i <= lat + 6; i++) begin
            step(12'h000, 1'b0);
            if (first < 0 && dout != 0) begin first = i; seen = int'(dout); end
        end
        check(first == lat, tag, "impulse latency", first, lat);
        check(seen == val, tag, "impulse value", seen, val);
    endtask

    initial begin
        @(negedge clk);

        // R1: reset state and first edge is a take edge
        cur_tag = "R1";
        do_reset(4'd2);
        check(core_smp == 0 && dout == 0, "R1", "reset outputs", int'(core_smp | dout), 0);
        step(12'h123, 1'b0);
        check(int'(core_smp) == 16'h1230, "R1", "first edge accepts", int'(core_smp), 16'h1230);
        step(12'h321, 1'b0);
        check(core_smp == 0, "R1", "second edge zero", int'(core_smp), 0);

        // R3: misaligned SYNC pulse forces take edge
        cur_tag = "R3";
        do_reset(4'd2);
        step(12'h001, 1'b1);           // take edge with SYNC high
        step(12'h9AB, 1'b0);           // free phase says skip, SYNC fall forces take
        check(int'(core_smp) == 16'h9AB0, "R3", "forced take", int'(core_smp), 16'h9AB0);
        step(12'h111, 1'b0);
        check(core_smp == 0, "R3", "zero after alignment", int'(core_smp), 0);

        // R2 / R4: held low, then half-rate square wave
        cur_tag = "R2";
        for (int i = 0; i < 60; i++) step(12'($urandom_range(0, 4095)), 1'b0);
        cur_tag = "R4";
        for (int i = 0; i < 60; i++) step(12'($urandom_range(0, 4095)), (i % 2) == 0);

        // R8: half-gain interpolation
        cur_tag = "R8";
        do_reset(4'd3);
        step(12'h800, 1'b0);
        check(int'(core_smp) == 16'hC000, "R8", "half gain min", int'(core_smp), 16'hC000);
        for (int i = 0; i < 40; i++) step(12'($urandom_range(0, 4095)), 1'b0);

        // R5: decimation with alignment and random data
        cur_tag = "R5";
        do_reset(4'd4);
        step(12'h000, 1'b1);
        for (int i = 0; i < 120; i++) step(12'($urandom_range(0, 4095)), 1'b0);

        // R6: equal-rate and pass-through ignore SYNC
        cur_tag = "R6";
        do_reset(4'd0);
        for (int i = 0; i < 80; i++) step(12'($urandom_range(0, 4095)), 1'($urandom_range(0, 1)));
        do_reset(4'd1);
        for (int i = 0; i < 80; i++) step(12'($urandom_range(0, 4095)), 1'($urandom_range(0, 1)));

        // R7: latencies; R10: undefined code behaves as equal-rate
        impulse_test(4'd0, 0, 34, 512, "R7");
        impulse_test(4'd2, 0, 34, 1024, "R7");
        impulse_test(4'd4, 1, 34, 512, "R7");
        impulse_test(4'd5, 0, 68, 1024, "R7");
        impulse_test(4'd6, 1, 68, 512, "R7");
        impulse_test(4'd15, 0, 34, 512, "R10");

        // R9: two-channel lock ignores later SYNC falls
        cur_tag = "R9";
        do_reset(4'd7);
        step(12'h001, 1'b1);
        step(12'h002, 1'b0);
        check(int'(core_smp) == 16'h0020, "R9", "aligned take", int'(core_smp), 16'h0020);
        step(12'h003, 1'b0);
        step(12'h004, 1'b1);
        step(12'h005, 1'b0);
        check(core_smp == 0, "R9", "late SYNC fall ignored", int'(core_smp), 0);
        for (int i = 0; i < 60; i++) step(12'($urandom_range(0, 4095)), 1'($urandom_range(0, 1)));
        do_reset(4'd8);
        step(12'h000, 1'b1);
        for (int i = 0; i < 80; i++) step(12'($urandom_range(0, 4095)), 1'($urandom_range(0, 1)));

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule